// File: doc/BRIEF.md
# Serial FRAM Transaction Sequencer

This block sits between on-chip logic and a serial ferroelectric memory attached over a four-wire SPI link in mode 0. The host hands it one request at a time on a parallel port: unlock writes, burst write, burst read or wipe the whole array. It then runs the complete chip-select script for that request on its own. That covers the opcode, a 16-bit address sent high byte first, and the data bytes. For writes and the wipe, it first sends a separate one-byte unlock frame.

Write bytes come in over a valid/ready port and read bytes leave over another one. When the host is slow on either side, the serial clock pauses with chip select held low, so the frame stays open. The serial clock runs at the system clock divided by a parameter, four by default. Chip select has guard times before the first edge, after the last edge and between frames.

Top module: `fram_spi_ctrl`

## Requirements
- R1: spiSck idles low, each SCK period lasts SCK_DIV system cycles, spiMosi holds the current bit while spiSck rises, spiMiso is sampled on the rising edge, and every byte is shifted most significant bit first.
- R2: Operation code 0 (unlock) produces exactly one chip-select frame that carries the single byte 0x06.
- R3: Operation code 1 (write) produces a 0x06 frame, raises chip select, then produces a second frame with 0x02, address bits 15:8, address bits 7:0 and then reqLen data bytes taken from wrData in order.
- R4: Operation code 2 (read) produces one frame with 0x03 and the two address bytes, followed by reqLen bytes of 0x00. The byte received during each of those is returned on rdData in order.
- R5: Operation code 3 (wipe) ignores reqAddr and reqLen. It produces a 0x06 frame, then a frame with 0x02, 0x00, 0x00 and exactly CLEAR_BYTES bytes of 0x00.
- R6: Whenever no operation runs, spiCsN is high and spiSck and spiMosi are low.
- R7: A new byte never starts shifting before all eight clock periods of the previous byte have completed.
- R8: reqReady is high only while idle, and a request seen while it is low has no effect. busy rises on acceptance and stays high while spiCsN is low, until the last frame's high-time guard has elapsed.
- R9: If wrValid is low when a write byte is due, or a read byte is still pending when the next dummy byte is due, spiSck pauses low with spiCsN held low, and the frame resumes afterwards.
- R10: spiCsN falls at least one SCK period before the first rising edge and rises at least one SCK period after the last falling edge. It stays high for at least one SCK period between frames.
- R11: While rdValid is high and rdReady is low, rdValid stays high and rdData does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request taken this cycle (idle) |
| reqOp | input | 2 | 0 unlock, 1 write, 2 read, 3 wipe |
| reqAddr | input | 16 | Start address |
| reqLen | input | LEN_W | Number of data bytes |
| busy | output | 1 | Operation in progress |
| wrData | input | 8 | Write byte |
| wrValid | input | 1 | Write byte offered |
| wrReady | output | 1 | Write byte taken this cycle |
| rdData | output | 8 | Read byte |
| rdValid | output | 1 | Read byte available |
| rdReady | input | 1 | Host takes the read byte |
| spiCsN | output | 1 | Chip select, active low |
| spiSck | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data to memory |
| spiMiso | input | 1 | Serial data from memory |

## Verification
A request is taken on the first edge with reqReady high. spiCsN falls on that same edge, and the first spiSck rise comes SCK_DIV+3 cycles later. Each byte then takes 8·SCK_DIV cycles, and rdValid rises one cycle after the last falling edge of a dummy byte. The bench does not count these latencies with fixed delays. Requests and data are driven on falling clock edges and the bench waits on the handshake outputs before it samples. A serial memory model timestamps every spiCsN and spiSck edge, so the SCK period and the three chip-select guard times are checked against one SCK period wherever they occur.

// File: rtl/fram_pkg.sv
package fram_pkg;

  typedef enum logic [1:0] {
    OP_UNLOCK = 2'd0,
    OP_WRITE  = 2'd1,
    OP_READ   = 2'd2,
    OP_WIPE   = 2'd3
  } fram_op_e;

  localparam logic [7:0] CMD_UNLOCK = 8'h06;
  localparam logic [7:0] CMD_WRITE  = 8'h02;
  localparam logic [7:0] CMD_READ   = 8'h03;

  // strobes from sequencer to shifter
  typedef struct packed {
    logic       load;
    logic [7:0] txByte;
  } shift_cmd_t;

  // status from shifter to sequencer
  typedef struct packed {
    logic done;
    logic active;
  } shift_stat_t;

endpackage

// File: rtl/fram_spi_shifter.sv
module fram_spi_shifter
  import fram_pkg::*;
#(
  parameter int SCK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  shift_cmd_t  cmd,
  output shift_stat_t stat,
  output logic [7:0]  rxByte,
  output logic        sck,
  output logic        mosi,
  input  logic        miso
);

  localparam int PH_W = (SCK_DIV > 2) ? $clog2(SCK_DIV) : 1;
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(SCK_DIV / 2 - 1);
  localparam logic [PH_W-1:0] PH_FALL = PH_W'(SCK_DIV - 1);

  logic            active;
  logic            done;
  logic            sckQ;
  logic [PH_W-1:0] phase;
  logic [2:0]      bitIdx;
  logic [7:0]      txShift;
  logic [7:0]      rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      done    <= 1'b0;
      sckQ    <= 1'b0;
      phase   <= '0;
      bitIdx  <= '0;
      txShift <= '0;
      rxShift <= '0;
      rxByte  <= '0;
    end else begin
      done <= 1'b0;
      if (cmd.load && !active) begin
        active  <= 1'b1;
        txShift <= cmd.txByte;
        phase   <= '0;
        bitIdx  <= '0;
      end else if (active) begin
        phase <= (phase == PH_FALL) ? '0 : phase + 1'b1;
        if (phase == PH_RISE) begin
          sckQ    <= 1'b1;
          rxShift <= {rxShift[6:0], miso};
        end
        if (phase == PH_FALL) begin
          sckQ    <= 1'b0;
          txShift <= {txShift[6:0], 1'b0};
          bitIdx  <= bitIdx + 3'd1;
          if (bitIdx == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
            rxByte <= rxShift;
          end
        end
      end
    end
  end

  assign sck         = sckQ;
  assign mosi        = active & txShift[7];
  assign stat.done   = done;
  assign stat.active = active;

  // R7
  no_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |-> !active);

  // R1
  sck_in_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sckQ) |-> active);

endmodule

// File: rtl/fram_spi_sequencer.sv
module fram_spi_sequencer
  import fram_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int CLEAR_BYTES = 32768,
  parameter int GUARD_CYC   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqOp,
  input  logic [15:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  output logic             busy,
  input  logic [7:0]       wrData,
  input  logic             wrValid,
  output logic             wrReady,
  output logic             rdValid,
  input  logic             rdReady,
  output logic             csN,
  output shift_cmd_t       cmd,
  input  shift_stat_t      stat
);

  localparam int CLR_W = $clog2(CLEAR_BYTES + 1);
  localparam int CNT_W = (LEN_W > CLR_W) ? LEN_W : CLR_W;
  localparam int TMR_W = $clog2(GUARD_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(GUARD_CYC - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LOAD, ST_SHIFT, ST_HOLD, ST_GAP
  } seq_state_e;

  seq_state_e       state;
  fram_op_e         curOp;
  logic [15:0]      addrQ;
  logic [CNT_W-1:0] remain;
  logic [1:0]       byteIdx;
  logic             unlockFrame;
  logic             lastData;
  logic [TMR_W-1:0] timer;
  logic             csNQ;
  logic             rdValidQ;

  logic [7:0] nextByte;
  logic       canSend;
  logic       frameEnd;
  logic       isData;

  // choose the next byte of the frame script
  always_comb begin
    nextByte = 8'h00;
    canSend  = 1'b0;
    frameEnd = 1'b0;
    isData   = 1'b0;
    if (unlockFrame) begin
      if (byteIdx == 2'd0) begin
        nextByte = CMD_UNLOCK;
        canSend  = 1'b1;
      end else begin
        frameEnd = 1'b1;
      end
    end else begin
      case (byteIdx)
        2'd0: begin
          nextByte = (curOp == OP_READ) ? CMD_READ : CMD_WRITE;
          canSend  = 1'b1;
        end
        2'd1: begin
          nextByte = addrQ[15:8];
          canSend  = 1'b1;
        end
        2'd2: begin
          nextByte = addrQ[7:0];
          canSend  = 1'b1;
        end
        default: begin
          if (remain == '0) begin
            frameEnd = 1'b1;
          end else begin
            isData = 1'b1;
            case (curOp)
              OP_WRITE: begin
                nextByte = wrData;
                canSend  = wrValid;
              end
              OP_READ: begin
                nextByte = 8'h00;
                canSend  = !rdValidQ;
              end
              default: begin
                nextByte = 8'h00;
                canSend  = 1'b1;
              end
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      curOp       <= OP_UNLOCK;
      addrQ       <= '0;
      remain      <= '0;
      byteIdx     <= '0;
      unlockFrame <= 1'b0;
      lastData    <= 1'b0;
      timer       <= '0;
      csNQ        <= 1'b1;
      rdValidQ    <= 1'b0;
    end else begin
      if (rdValidQ && rdReady) rdValidQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            curOp       <= fram_op_e'(reqOp);
            addrQ       <= (fram_op_e'(reqOp) == OP_WIPE) ? 16'h0000 : reqAddr;
            remain      <= (fram_op_e'(reqOp) == OP_WIPE) ? CNT_W'(CLEAR_BYTES)
                                                         : CNT_W'(reqLen);
            unlockFrame <= (fram_op_e'(reqOp) != OP_READ);
            byteIdx     <= '0;
            csNQ        <= 1'b0;
            timer       <= TMR_LOAD;
            state       <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (timer == '0) state <= ST_LOAD;
          else             timer <= timer - 1'b1;
        end
        ST_LOAD: begin
          if (frameEnd) begin
            timer <= TMR_LOAD;
            state <= ST_HOLD;
          end else if (canSend) begin
            byteIdx  <= (byteIdx == 2'd3) ? 2'd3 : byteIdx + 2'd1;
            lastData <= isData;
            if (isData) remain <= remain - 1'b1;
            state <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (stat.done) begin
            if (lastData && curOp == OP_READ) rdValidQ <= 1'b1;
            state <= ST_LOAD;
          end
        end
        ST_HOLD: begin
          if (timer == '0) begin
            csNQ  <= 1'b1;
            timer <= TMR_LOAD;
            state <= ST_GAP;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        ST_GAP: begin
          if (timer != '0) begin
            timer <= timer - 1'b1;
          end else if (unlockFrame && curOp != OP_UNLOCK) begin
            unlockFrame <= 1'b0;
            byteIdx     <= '0;
            csNQ        <= 1'b0;
            timer       <= TMR_LOAD;
            state       <= ST_SETUP;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady   = (state == ST_IDLE);
  assign busy       = (state != ST_IDLE);
  assign wrReady    = (state == ST_LOAD) && isData && (curOp == OP_WRITE);
  assign rdValid    = rdValidQ;
  assign csN        = csNQ;
  assign cmd.load   = (state == ST_LOAD) && canSend && !frameEnd;
  assign cmd.txByte = nextByte;

  // R6
  cs_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    csNQ |-> !stat.active);

  // R9
  wr_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrReady && !wrValid) |=> (!stat.active && !csNQ));

  // R10
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csNQ) |=> csNQ);

endmodule

// File: rtl/fram_spi_ctrl.sv
module fram_spi_ctrl
  import fram_pkg::*;
#(
  parameter int SCK_DIV     = 4,
  parameter int LEN_W       = 16,
  parameter int CLEAR_BYTES = 32768
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqOp,
  input  logic [15:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  output logic             busy,
  input  logic [7:0]       wrData,
  input  logic             wrValid,
  output logic             wrReady,
  output logic [7:0]       rdData,
  output logic             rdValid,
  input  logic             rdReady,
  output logic             spiCsN,
  output logic             spiSck,
  output logic             spiMosi,
  input  logic             spiMiso
);

  shift_cmd_t  shCmd;
  shift_stat_t shStat;

  fram_spi_sequencer #(
    .LEN_W      (LEN_W),
    .CLEAR_BYTES(CLEAR_BYTES),
    .GUARD_CYC  (SCK_DIV)
  ) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .reqOp   (reqOp),
    .reqAddr (reqAddr),
    .reqLen  (reqLen),
    .busy    (busy),
    .wrData  (wrData),
    .wrValid (wrValid),
    .wrReady (wrReady),
    .rdValid (rdValid),
    .rdReady (rdReady),
    .csN     (spiCsN),
    .cmd     (shCmd),
    .stat    (shStat)
  );

  fram_spi_shifter #(
    .SCK_DIV(SCK_DIV)
  ) u_shift (
    .clk   (clk),
    .rstN  (rstN),
    .cmd   (shCmd),
    .stat  (shStat),
    .rxByte(rdData),
    .sck   (spiSck),
    .mosi  (spiMosi),
    .miso  (spiMiso)
  );

  // R8
  busy_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    !spiCsN |-> busy);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));

endmodule

// File: tb/fram_spi_ctrl_tb.sv
module fram_spi_ctrl_tb;

  localparam int WIPE_N = 48;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = 2'd0;
  logic [15:0] reqAddr = 16'h0;
  logic [15:0] reqLen = 16'h0;
  logic        busy;
  logic [7:0]  wrData = 8'h0;
  logic        wrValid = 1'b0;
  logic        wrReady;
  logic [7:0]  rdData;
  logic        rdValid;
  logic        rdReady = 1'b0;
  logic        spiCsN, spiSck, spiMosi;
  logic        spiMiso = 1'b0;

  always #5 clk = ~clk;

  fram_spi_ctrl #(.CLEAR_BYTES(WIPE_N)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqLen(reqLen), .busy(busy),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady),
    .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- serial memory model ----------------
  logic [7:0]  mem [0:1023];
  logic [7:0]  sh = 8'h0, op = 8'h0, tx = 8'h0;
  logic [15:0] adr = 16'h0;
  logic        wel = 1'b0;
  int bitN = 0, byteN = 0, frames = 0, noWel = 0, dummyBad = 0;
  logic [7:0]  frameOp [0:31];
  int          frameLen [0:31];

  initial for (int i = 0; i < 1024; i++) mem[i] = 8'(i) ^ 8'h5A;

  always @(negedge spiCsN) if (rstN) begin
    bitN = 0; byteN = 0; tx = 8'h0;
  end

  always @(posedge spiCsN) if (rstN) begin
    if (frames < 32) begin
      frameOp[frames]  = op;
      frameLen[frames] = byteN;
    end
    frames++;
    if (op == 8'h02) wel = 1'b0;
  end

  always @(posedge spiSck) if (rstN && !spiCsN) begin
    sh = {sh[6:0], spiMosi};
    bitN++;
    if (bitN == 8) begin
      bitN = 0;
      case (byteN)
        0: begin op = sh; if (sh == 8'h06) wel = 1'b1; end
        1: adr[15:8] = sh;
        2: adr[7:0] = sh;
        default: begin
          if (op == 8'h02) begin
            if (wel) mem[adr[9:0]] = sh; else noWel++;
            adr++;
          end else if (op == 8'h03 && sh != 8'h00) begin
            dummyBad++;
          end
        end
      endcase
      if (op == 8'h03 && byteN >= 2) begin
        tx = mem[adr[9:0]];
        adr++;
      end
      byteN++;
    end
  end

  always @(negedge spiSck) if (rstN && !spiCsN) begin
    spiMiso <= tx[7];
    tx = {tx[6:0], 1'b0};
  end

  // ---------------- edge timing monitor ----------------
  realtime tCsFall = 0, tCsRise = -1000, tSckRise = 0, tSckFall = 0;
  bit firstEdge = 1'b0;
  int perBad = 0, guardBad = 0;

  always @(negedge spiCsN) if (rstN) begin
    if ($realtime - tCsRise < 40.0) guardBad++;
    tCsFall = $realtime;
    firstEdge = 1'b1;
  end
  always @(posedge spiCsN) if (rstN) begin
    if ($realtime - tSckFall < 40.0) guardBad++;
    tCsRise = $realtime;
  end
  always @(posedge spiSck) if (rstN) begin
    if (spiCsN) perBad++;
    if (firstEdge && ($realtime - tCsFall < 40.0)) guardBad++;
    if (!firstEdge && ($realtime - tSckRise < 40.0)) perBad++;
    firstEdge = 1'b0;
    tSckRise = $realtime;
  end
  always @(negedge spiSck) if (rstN) tSckFall = $realtime;

  // ---------------- helpers ----------------
  logic [7:0] wbuf [0:4];
  initial begin
    wbuf[0] = 8'hC3; wbuf[1] = 8'h00; wbuf[2] = 8'hFF;
    wbuf[3] = 8'h81; wbuf[4] = 8'h3C;
  end

  task automatic issue(input logic [1:0] o, input logic [15:0] a, input logic [15:0] n);
    @(negedge clk);
    reqOp = o; reqAddr = a; reqLen = n; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy == 1'b1, "R8", "busy after accept", busy, 1);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    chk(spiCsN == 1'b1 && spiSck == 1'b0 && spiMosi == 1'b0, "R6",
        "idle pins cs/sck/mosi", {spiCsN, spiSck, spiMosi}, 3'b100);
  endtask

  task automatic t_reset();
    chk(spiCsN == 1'b1 && spiSck == 1'b0 && spiMosi == 1'b0, "R6",
        "reset pins", {spiCsN, spiSck, spiMosi}, 3'b100);
    chk(busy == 1'b0 && reqReady == 1'b1 && rdValid == 1'b0, "R8",
        "reset busy/ready/rdValid", {busy, reqReady, rdValid}, 3'b010);
  endtask

  task automatic t_unlock();
    int f0 = frames;
    issue(2'd0, 16'h1234, 16'd9);
    waitIdle();
    chk(frames == f0 + 1, "R2", "unlock frame count", frames - f0, 1);
    chk(frameOp[f0] == 8'h06 && frameLen[f0] == 1, "R2", "unlock frame byte/len",
        {frameOp[f0], 8'(frameLen[f0])}, 16'h0601);
  endtask

  task automatic t_write();
    int f0 = frames;
    fork
      issue(2'd1, 16'h0010, 16'd5);
      begin
        for (int i = 0; i < 5; i++) begin
          if (i == 2) begin
            repeat (70) @(negedge clk);
            chk(spiCsN == 1'b0 && spiSck == 1'b0 && wrReady == 1'b1, "R9",
                "write stall holds frame", {spiCsN, spiSck, wrReady}, 3'b001);
            repeat (10) @(negedge clk);
          end
          @(negedge clk);
          wrValid = 1'b1; wrData = wbuf[i];
          while (!wrReady) @(negedge clk);
          @(negedge clk);
          wrValid = 1'b0;
        end
      end
    join
    waitIdle();
    chk(frames == f0 + 2, "R3", "write frame count", frames - f0, 2);
    chk(frameOp[f0] == 8'h06 && frameLen[f0] == 1, "R3", "unlock before write",
        {frameOp[f0], 8'(frameLen[f0])}, 16'h0601);
    chk(frameOp[f0+1] == 8'h02 && frameLen[f0+1] == 8, "R3", "write frame op/len",
        {frameOp[f0+1], 8'(frameLen[f0+1])}, 16'h0208);
    chk(noWel == 0, "R3", "write without unlock", noWel, 0);
    for (int i = 0; i < 5; i++)
      chk(mem[16 + i] == wbuf[i], "R1", "stored byte MSB-first", mem[16 + i], wbuf[i]);
  endtask

  task automatic t_read();
    int f0 = frames;
    int stableBad = 0;
    fork
      issue(2'd2, 16'h0010, 16'd5);
      begin
        for (int i = 0; i < 5; i++) begin
          logic [7:0] held;
          @(negedge clk);
          while (!rdValid) @(negedge clk);
          held = rdData;
          if (i == 1) begin
            repeat (50) begin
              @(negedge clk);
              if (rdData != held || !rdValid) stableBad++;
            end
            chk(spiSck == 1'b0 && spiCsN == 1'b0, "R9", "read stall holds frame",
                {spiCsN, spiSck}, 2'b00);
          end
          chk(held == wbuf[i], "R4", "read byte", held, wbuf[i]);
          rdReady = 1'b1;
          @(negedge clk);
          rdReady = 1'b0;
        end
      end
    join
    waitIdle();
    chk(stableBad == 0, "R11", "rdData held under backpressure", stableBad, 0);
    chk(frames == f0 + 1 && frameOp[f0] == 8'h03 && frameLen[f0] == 8, "R4",
        "read frame op/len", {frameOp[f0], 8'(frameLen[f0])}, 16'h0308);
    chk(dummyBad == 0, "R4", "dummy bytes zero", dummyBad, 0);
  endtask

  task automatic t_busy_ignore();
    int f0 = frames;
    issue(2'd2, 16'h0200, 16'd2);
    fork
      begin
        for (int i = 0; i < 2; i++) begin
          @(negedge clk);
          while (!rdValid) @(negedge clk);
          chk(rdData == 8'(8'h5A + i), "R4", "read unwritten area", rdData, 8'h5A + i);
          rdReady = 1'b1;
          @(negedge clk);
          rdReady = 1'b0;
        end
      end
      begin
        repeat (10) @(negedge clk);
        reqOp = 2'd0; reqValid = 1'b1;
        chk(reqReady == 1'b0, "R8", "not ready while busy", reqReady, 0);
        repeat (3) @(negedge clk);
        reqValid = 1'b0;
      end
    join
    waitIdle();
    repeat (20) @(negedge clk);
    chk(frames == f0 + 1 && frameOp[f0] == 8'h03, "R8", "request while busy ignored",
        frames - f0, 1);
  endtask

  task automatic t_wipe();
    int f0 = frames;
    int nz = 0;
    issue(2'd3, 16'hFFFF, 16'd7);
    waitIdle();
    chk(frames == f0 + 2, "R5", "wipe frame count", frames - f0, 2);
    chk(frameOp[f0] == 8'h06 && frameLen[f0] == 1, "R5", "wipe unlock frame",
        {frameOp[f0], 8'(frameLen[f0])}, 16'h0601);
    chk(frameOp[f0+1] == 8'h02 && frameLen[f0+1] == 3 + WIPE_N, "R5", "wipe frame op/len",
        {frameOp[f0+1], 8'(frameLen[f0+1])}, {8'h02, 8'(3 + WIPE_N)});
    for (int i = 0; i < WIPE_N; i++) if (mem[i] != 8'h00) nz++;
    chk(nz == 0, "R5", "wiped bytes nonzero", nz, 0);
    chk(mem[WIPE_N] == (8'(WIPE_N) ^ 8'h5A), "R5", "byte past wipe kept",
        mem[WIPE_N], 8'(WIPE_N) ^ 8'h5A);
    fork
      issue(2'd2, 16'h0010, 16'd2);
      begin
        for (int i = 0; i < 2; i++) begin
          @(negedge clk);
          while (!rdValid) @(negedge clk);
          chk(rdData == 8'h00, "R5", "read after wipe", rdData, 0);
          rdReady = 1'b1;
          @(negedge clk);
          rdReady = 1'b0;
        end
      end
    join
    waitIdle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlock();
    t_write();
    t_read();
    t_busy_ignore();
    t_wipe();
    chk(perBad == 0, "R1", "SCK period / R7 byte overlap", perBad, 0);
    chk(guardBad == 0, "R10", "chip-select guard times", guardBad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule